// File: doc/BRIEF.md
# Eight-Pin GPIO Controller with Interrupt Detection

This block is a general-purpose I/O controller for eight pads. It sits on a simple 32-bit register bus with a select, a write strobe, a 12-bit byte address and combinational read data. Software sets the direction of each pin and drives or samples the pins through a data window. In that window the word address bits act as a per-pin access mask, so one access can touch any subset of the pins without a read-modify-write.

Every pin has its own interrupt detector. The pin input first passes through a two-flop synchronizer. The detector can sense a level (high or low), a single edge (rising or falling), or both edges. Raw status, masked status and a write-one-to-clear acknowledge register let software find and retire events. One interrupt output is the OR of all masked status bits. The pad output enable comes directly from the direction bits.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every register holds 0: all pins are inputs with `pin_oe_o` = 0 and `pin_out_o` = 0, all interrupts are disabled, raw status reads 0 and `irq_o` is low.
- R2: The direction register at byte offset 0x400 holds one bit per pin. A 1 makes the pin an output and a 0 makes it an input. `pin_oe_o` equals this register from the clock edge that commits the write.
- R3: Writes to byte offsets 0x000 to 0x3FC go to the data register. Address bits [9:2] form a mask, with bit 2+i for pin i. Only output-register bits whose mask bit is 1 take the value from write data, and the others keep their value.
- R4: A read from the data window returns, for each pin whose mask bit is 1, the output register value if the pin is an output or the synchronized pin level if it is an input. Every bit whose mask bit is 0 reads as 0, and bits 31:8 read as 0.
- R5: A data write has no effect on the stored output value of a pin that is an input at that time. A pin switched to output later drives the value it held before.
- R6: In the interrupt-sense register at 0x404, a bit of 1 selects level detection. In level mode the polarity register at 0x40C selects active-high (1) or active-low (0), and the raw status bit follows the live synchronized pin condition.
- R7: A sense bit of 0 selects edge detection. Polarity 1 detects rising edges and polarity 0 detects falling edges. A detected edge sets the raw status bit, and the bit stays set after the pin returns to its earlier level.
- R8: A 1 in the both-edges register at 0x408 makes an edge-mode pin detect rising and falling edges, and the polarity bit for that pin is ignored.
- R9: Raw status reads at 0x414. Masked status at 0x418 is raw status AND the enable register at 0x410. `irq_o` is high exactly when some masked status bit is 1.
- R10: Writing to the clear register at 0x41C clears each edge-latched raw bit whose write-data bit is 1. Bits written 0 are unaffected, and level-mode raw bits are never cleared by it.
- R11: If an edge is detected on a pin in the same cycle that a clear of that pin's bit commits, the raw bit ends set.
- R12: A pin change reaches the level-mode raw status after two clock edges and not after one. Edges are judged against the previous synchronized sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Access select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, 0 when not selected for read |
| pin_in_i | input | 8 | Asynchronous pad inputs |
| pin_out_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
Two functions can collide in one cycle: a write-one-to-clear to the status register and a freshly detected edge on the same pin. The bench provokes this by changing a pin and then timing a clear write so that it commits on the edge where the edge detector latches, which is the third clock after the change. It judges the result from raw status: the colliding pin must stay set while a previously latched pin cleared by the same write must drop. A second overlap is a level bit being cleared while its condition holds; that bit must read set again immediately.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;
  localparam logic [AW-1:0] OFF_DIR   = 12'h400;
  localparam logic [AW-1:0] OFF_SENSE = 12'h404;
  localparam logic [AW-1:0] OFF_DUAL  = 12'h408;
  localparam logic [AW-1:0] OFF_POL   = 12'h40C;
  localparam logic [AW-1:0] OFF_IE    = 12'h410;
  localparam logic [AW-1:0] OFF_RAW   = 12'h414;
  localparam logic [AW-1:0] OFF_MSK   = 12'h418;
  localparam logic [AW-1:0] OFF_CLR   = 12'h41C;
endpackage

// File: rtl/gpio_ctrl_sync.sv
module gpio_ctrl_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_ctrl_pin_irq.sv
module gpio_ctrl_pin_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  input  logic level_i,
  input  logic dual_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic raw_o
);
  logic prev_q, edge_q, rise, fall, hit;

  assign rise = s_i & ~prev_q;
  assign fall = ~s_i & prev_q;
  assign hit  = ~level_i & (dual_i ? (rise | fall) : (pol_i ? rise : fall));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      prev_q <= s_i;
      if (hit)        edge_q <= 1'b1;  // new edge beats a same-cycle clear
      else if (clr_i) edge_q <= 1'b0;
    end
  end

  assign raw_o = level_i ? (pol_i ? s_i : ~s_i) : edge_q;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPIN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_sel_i,
  input  logic            bus_wr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  input  logic [NPIN-1:0] pin_in_i,
  output logic [NPIN-1:0] pin_out_o,
  output logic [NPIN-1:0] pin_oe_o,
  output logic            irq_o
);
  localparam int unsigned MASK_LO = 2;
  localparam int unsigned MASK_HI = NPIN + 1;
  localparam int unsigned WIN_LO  = NPIN + 2;

  logic [NPIN-1:0] dir_q, sense_q, dual_q, pol_q, ie_q, out_q;
  logic [NPIN-1:0] pin_s, raw, masked, clr, amask, wbits;
  logic            wr_en, data_hit;
  logic            unused_bits;

  assign unused_bits = ^{bus_wdata_i[DW-1:NPIN], bus_addr_i[MASK_LO-1:0]};

  assign wr_en    = bus_sel_i & bus_wr_i;
  assign amask    = bus_addr_i[MASK_HI:MASK_LO];
  assign data_hit = (bus_addr_i[AW-1:WIN_LO] == '0);
  assign wbits    = bus_wdata_i[NPIN-1:0];
  assign clr      = (wr_en && bus_addr_i == OFF_CLR) ? wbits : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      sense_q <= '0;
      dual_q  <= '0;
      pol_q   <= '0;
      ie_q    <= '0;
      out_q   <= '0;
    end else if (wr_en) begin
      if (data_hit) begin
        // only masked bits of pins currently driven as outputs
        out_q <= (out_q & ~(amask & dir_q)) | (wbits & amask & dir_q);
      end else begin
        unique case (bus_addr_i)
          OFF_DIR:   dir_q   <= wbits;
          OFF_SENSE: sense_q <= wbits;
          OFF_DUAL:  dual_q  <= wbits;
          OFF_POL:   pol_q   <= wbits;
          OFF_IE:    ie_q    <= wbits;
          default:   ;
        endcase
      end
    end
  end

  gpio_ctrl_sync #(.W(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (pin_s)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gpio_ctrl_pin_irq u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .s_i     (pin_s[i]),
      .level_i (sense_q[i]),
      .dual_i  (dual_q[i]),
      .pol_i   (pol_q[i]),
      .clr_i   (clr[i]),
      .raw_o   (raw[i])
    );
  end

  assign masked = raw & ie_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_wr_i) begin
      if (data_hit) begin
        bus_rdata_o[NPIN-1:0] = amask & ((dir_q & out_q) | (~dir_q & pin_s));
      end else begin
        unique case (bus_addr_i)
          OFF_DIR:   bus_rdata_o[NPIN-1:0] = dir_q;
          OFF_SENSE: bus_rdata_o[NPIN-1:0] = sense_q;
          OFF_DUAL:  bus_rdata_o[NPIN-1:0] = dual_q;
          OFF_POL:   bus_rdata_o[NPIN-1:0] = pol_q;
          OFF_IE:    bus_rdata_o[NPIN-1:0] = ie_q;
          OFF_RAW:   bus_rdata_o[NPIN-1:0] = raw;
          OFF_MSK:   bus_rdata_o[NPIN-1:0] = masked;
          default:   ;
        endcase
      end
    end
  end

  assign pin_out_o = out_q;
  assign pin_oe_o  = dir_q;
  assign irq_o     = |masked;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPIN = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bus_sel_i,
  input logic            bus_wr_i,
  input logic [AW-1:0]   bus_addr_i,
  input logic [DW-1:0]   bus_wdata_i,
  input logic [DW-1:0]   bus_rdata_o,
  input logic [NPIN-1:0] pin_out_o,
  input logic [NPIN-1:0] pin_oe_o,
  input logic            irq_o,
  input logic [NPIN-1:0] ie_q
);
  logic            dwin;
  logic [DW-1:0]   rmask;
  assign dwin  = (bus_addr_i[AW-1:NPIN+2] == '0);
  assign rmask = {{(DW-NPIN){1'b0}}, bus_addr_i[NPIN+1:2]};

  p_oe_follows_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_wr_i && bus_addr_i == OFF_DIR)
    |=> pin_oe_o == $past(bus_wdata_i[NPIN-1:0]));

  p_unmasked_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_wr_i && dwin)
    |=> ((pin_out_o ^ $past(pin_out_o)) & ~$past(bus_addr_i[NPIN+1:2])) == '0);

  p_read_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_wr_i && dwin) |-> (bus_rdata_o & ~rmask) == '0);

  p_input_out_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pin_out_o ^ $past(pin_out_o)) & ~$past(pin_oe_o)) == '0);

  p_irq_needs_enable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q == '0) |-> !irq_o);
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NPIN(NPIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pin_out_o   (pin_out_o),
  .pin_oe_o    (pin_oe_o),
  .irq_o       (irq_o),
  .ie_q        (ie_q)
);

// File: tb/gpio_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pins = '0;
  logic [7:0]  pout, poe;
  logic        irq;
  int          checks = 0, errors = 0;

  localparam logic [11:0] A_DIR = 12'h400, A_SEN = 12'h404, A_DUA = 12'h408,
                          A_POL = 12'h40C, A_IE = 12'h410, A_RAW = 12'h414,
                          A_MSK = 12'h418, A_CLR = 12'h41C;

  always #2.5 clk = ~clk;

  gpio_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_in_i(pins), .pin_out_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [11:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic br(input logic [11:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  outm, dirm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 oe", {24'h0, poe}, 32'h0);
    check("R1 out", {24'h0, pout}, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    br(A_DIR, d); check("R1 dir", d, 32'h0);
    br(A_IE, d);  check("R1 ie", d, 32'h0);
    br(A_RAW, d); check("R1 raw", d, 32'h0);

    // R2 every direction pattern
    for (int v = 0; v < 256; v++) begin
      bw(A_DIR, 32'(v));
      check("R2 oe", {24'h0, poe}, 32'(v));
    end

    // R5 write to input pins ignored
    bw(A_DIR, 32'hF0);
    bw(12'h3FC, 32'hFF);
    check("R5 inputs untouched", {24'h0, pout}, 32'hF0);
    bw(A_DIR, 32'hFF);
    check("R5 held value driven", {24'h0, pout}, 32'hF0);
    outm = 8'hF0;

    // R3 every write mask
    for (int m = 0; m < 256; m++) begin
      logic [7:0] v;
      v = 8'((m * 37 + 11) & 255);
      bw(12'(m << 2), {24'hFFFFFF, v});
      outm = (outm & ~8'(m)) | (v & 8'(m));
      check("R3 masked write", {24'h0, pout}, {24'h0, outm});
    end

    // R4 every read mask, mixed directions
    dirm = 8'h0F;
    bw(A_DIR, {24'h0, dirm});
    pins = 8'hA5;
    settle();
    for (int m = 0; m < 256; m++) begin
      br(12'(m << 2), d);
      check("R4 masked read", d, {24'h0, 8'(m) & ((dirm & outm) | (~dirm & pins))});
    end

    // R6 level modes, R12 latency, R10 level not clearable
    bw(A_DIR, 32'h0);
    bw(A_SEN, 32'h03);
    bw(A_POL, 32'h01);
    bw(A_IE, 32'hFF);
    pins = 8'h00;
    settle();
    bw(A_CLR, 32'hFF);
    br(A_RAW, d); check("R6 low active, high idle", d, 32'h02);
    check("R9 irq from level", {31'h0, irq}, 32'h1);
    pins = 8'h03;
    @(negedge clk);
    br(A_RAW, d); check("R12 not after one edge", d, 32'h02);
    @(negedge clk);
    br(A_RAW, d); check("R12 R6 after two edges", d, 32'h01);
    bw(A_CLR, 32'h03);
    br(A_RAW, d); check("R10 level bit survives clear", d, 32'h01);

    // R7 single edges latch
    bw(A_SEN, 32'h0);
    pins = 8'h00;
    bw(A_POL, 32'h0F);
    settle();
    bw(A_CLR, 32'hFF);
    br(A_RAW, d); check("R10 all cleared", d, 32'h0);
    pins = 8'hFF;
    settle();
    br(A_RAW, d); check("R7 rising", d, 32'h0F);
    pins = 8'h00;
    settle();
    br(A_RAW, d); check("R7 falling and latched", d, 32'hFF);

    // R9 masking
    bw(A_IE, 32'h00);
    br(A_MSK, d); check("R9 masked none", d, 32'h0);
    check("R9 irq off", {31'h0, irq}, 32'h0);
    bw(A_IE, 32'h10);
    br(A_MSK, d); check("R9 masked one", d, 32'h10);
    check("R9 irq on", {31'h0, irq}, 32'h1);
    bw(A_CLR, 32'h0F);
    br(A_RAW, d); check("R10 partial clear", d, 32'hF0);
    bw(A_CLR, 32'hF0);
    check("R9 irq cleared", {31'h0, irq}, 32'h0);

    // R8 both edges, polarity ignored
    bw(A_DUA, 32'h81);
    bw(A_POL, 32'h00);
    pins = 8'h01;
    settle();
    br(A_RAW, d); check("R8 rise despite pol0", d, 32'h01);
    bw(A_CLR, 32'hFF);
    pins = 8'h00;
    settle();
    br(A_RAW, d); check("R8 fall", d, 32'h01);
    bw(A_CLR, 32'hFF);
    pins = 8'h80;
    settle();
    br(A_RAW, d); check("R8 pin7 rise", d, 32'h80);

    // R11 edge and clear in same cycle
    bw(A_DUA, 32'h00);
    bw(A_POL, 32'hFF);
    pins = 8'h00;
    settle();
    bw(A_CLR, 32'hFF);
    pins = 8'h02;
    settle();
    br(A_RAW, d); check("R11 setup", d, 32'h02);
    pins = 8'h03;
    @(negedge clk);
    @(negedge clk);
    bw(A_CLR, 32'h03);
    br(A_RAW, d); check("R11 edge wins, old bit cleared", d, 32'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule